// File: doc/BRIEF.md
# Storage-Qualified Capture Buffer

This block records words from a probe bus into an on-chip sample memory. A per-sample qualifier decides whether each probe word is written. The qualifier is a Boolean function of a few chosen match-event bits. It is held as a truth table that is loaded at run time, and it can be switched off so that every sample is kept. A separate trigger pulse, coming from an external sequencer, decides when the capture ends. The trigger does not decide which samples are kept.

After an arm pulse, qualified samples go into a circular region of memory. When the trigger arrives, the sample on that cycle is always written and its address is recorded. Writing then continues until a programmed number of further qualified samples has been stored. At that point the block raises its done flag and freezes until the next arm. The stored-sample count saturates at the memory depth. If the trigger comes early, the count reports only the entries that were actually written.

A host unloads the memory through a simple read port. The oldest sample sits at physical address 0 when the count is below the depth. Otherwise it sits one position after the last post-trigger sample, that is at `(trig_addr + post_len + 1) mod DEPTH` once `post_len` has been clamped.

Top module: `sq_capture_buf`

## Requirements
- R1: After reset, `done` is 0, `stored_cnt` is 0 and `trig_addr` is 0. Until the first arm, no sample is written and triggers have no effect.
- R2: An `arm` pulse takes priority over every other input. It clears `done`, `stored_cnt`, `trig_addr` and the write address, and capture starts with the cycle after the arm.
- R3: With `qual_en` = 1, a pre- or post-trigger sample is written only if `qual_tbl[idx]` is 1. Index bit k of `idx` is the event bit chosen by field k of `qual_sel`, where field k occupies bits `[k*SW +: SW]`.
- R4: With `qual_en` = 0, every sample in the capture window is written.
- R5: The write address starts at 0, advances by one per stored sample and wraps from DEPTH-1 to 0. `stored_cnt` rises by one per stored sample and saturates at DEPTH.
- R6: The sample present on the cycle `trig` is first seen while capturing is always written, whatever the qualifier says. Its address appears on `trig_addr` from the next cycle on.
- R7: After the trigger sample, exactly `post_len` further qualified samples are written, and then `done` rises on the cycle after the last one. A `post_len` above DEPTH-1 acts as DEPTH-1. A `post_len` of 0 raises `done` on the cycle after the trigger.
- R8: While `done` is 1 and no arm is applied, no sample is written, and `trig`, `probe_data` and `match_evt` change neither the memory, nor `stored_cnt`, nor `trig_addr`.
- R9: `rd_data` shows the memory word at `rd_addr` one clock after the address is presented (default registered variant).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| arm | input | 1 | Start a new capture |
| probe_data | input | DATA_W | Sample word |
| match_evt | input | EVT_W | Match-unit event bits |
| trig | input | 1 | Trigger pulse from the sequencer |
| qual_en | input | 1 | 1: apply the qualifier, 0: store every sample |
| qual_sel | input | SEL_N*SW | Event bit chosen for each truth-table index bit |
| qual_tbl | input | 2**SEL_N | Truth table of the qualifier |
| post_len | input | CW | Number of qualified samples to store after the trigger |
| done | output | 1 | Capture complete |
| stored_cnt | output | CW | Number of valid entries in memory |
| trig_addr | output | AW | Address of the trigger sample |
| rd_addr | input | AW | Readout address |
| rd_data | output | DATA_W | Readout word |

## Verification
The bench sweeps all sixteen truth tables of a two-input qualifier while the event bits step through every combination. This separates a wrong index order, a wrong table bit and a wrong event selection. Runs with the qualifier off are used to tell wrap-around from partial fill, by triggering both before and after the memory fills. Those runs also test a `post_len` beyond the depth and a `post_len` of zero. A table of all zeros shows that the trigger sample is forced into memory. Activity before arm and after done shows that both states are frozen.

// File: rtl/sqcb_pkg.sv
package sqcb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PRE  = 2'd1,
      ST_POST = 2'd2,
      ST_DONE = 2'd3
   } cap_state_t;
endpackage

// File: rtl/sqcb_qualify.sv
module sqcb_qualify #(
   parameter int EVT_W = 16,
   parameter int SEL_N = 4,
   localparam int SW  = $clog2(EVT_W),
   localparam int TBL = 1 << SEL_N
) (
   input  logic [EVT_W-1:0]    evt,
   input  logic [SEL_N*SW-1:0] evt_sel,
   input  logic [TBL-1:0]      tbl,
   input  logic                en,
   output logic                qual
);
   logic [SEL_N-1:0] idx;

   for (genvar g = 0; g < SEL_N; g++) begin : g_pick
      logic [SW-1:0] s;
      assign s = evt_sel[g*SW +: SW];
      if ((1 << SW) == EVT_W) begin : g_full
         assign idx[g] = evt[s];
      end else begin : g_guard
         assign idx[g] = (int'(s) < EVT_W) ? evt[s] : 1'b0;
      end
   end

   assign qual = en ? tbl[idx] : 1'b1;
endmodule

// File: rtl/sqcb_ctrl.sv
module sqcb_ctrl
   import sqcb_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          arm,
   input  logic          trig,
   input  logic          qual,
   input  logic [CW-1:0] post_len,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic          done,
   output logic [CW-1:0] count,
   output logic [AW-1:0] taddr,
   output logic          capturing
);
   localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL    = CW'(DEPTH);
   localparam logic [CW-1:0] MAXPOST = CW'(DEPTH - 1);
   localparam logic [CW-1:0] ONE     = CW'(1);

   cap_state_t    state;
   logic [CW-1:0] remain;
   logic [CW-1:0] post_eff;

   assign post_eff = (post_len > MAXPOST) ? MAXPOST : post_len;

   always_comb begin
      we = 1'b0;
      if (!arm) begin
         unique case (state)
            ST_PRE:  we = qual | trig;
            ST_POST: we = qual;
            default: we = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         waddr  <= '0;
         count  <= '0;
         remain <= '0;
         taddr  <= '0;
      end else if (arm) begin
         state  <= ST_PRE;
         waddr  <= '0;
         count  <= '0;
         remain <= '0;
         taddr  <= '0;
      end else begin
         if (we) begin
            waddr <= (waddr == LAST) ? '0 : waddr + AW'(1);
            if (count != FULL) count <= count + ONE;
         end
         unique case (state)
            ST_PRE: if (trig) begin
               taddr  <= waddr;
               remain <= post_eff;
               state  <= (post_eff == '0) ? ST_DONE : ST_POST;
            end
            ST_POST: if (qual) begin
               remain <= remain - ONE;
               if (remain == ONE) state <= ST_DONE;
            end
            default: ;
         endcase
      end
   end

   assign done      = (state == ST_DONE);
   assign capturing = (state == ST_PRE) || (state == ST_POST);
endmodule

// File: rtl/sqcb_mem.sv
module sqcb_mem #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 64,
   parameter bit RD_REG = 1'b1,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk) rdata <= cells[raddr];
   end else begin : g_rd_comb
      assign rdata = cells[raddr];
   end
endmodule

// File: rtl/sq_capture_buf.sv
module sq_capture_buf #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 64,
   parameter int EVT_W  = 16,
   parameter int SEL_N  = 4,
   parameter bit RD_REG = 1'b1,
   localparam int AW  = $clog2(DEPTH),
   localparam int CW  = $clog2(DEPTH + 1),
   localparam int SW  = $clog2(EVT_W),
   localparam int TBL = 1 << SEL_N
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                arm,
   input  logic [DATA_W-1:0]   probe_data,
   input  logic [EVT_W-1:0]    match_evt,
   input  logic                trig,
   input  logic                qual_en,
   input  logic [SEL_N*SW-1:0] qual_sel,
   input  logic [TBL-1:0]      qual_tbl,
   input  logic [CW-1:0]       post_len,
   output logic                done,
   output logic [CW-1:0]       stored_cnt,
   output logic [AW-1:0]       trig_addr,
   input  logic [AW-1:0]       rd_addr,
   output logic [DATA_W-1:0]   rd_data
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("sq_capture_buf: DEPTH must be at least 2");
   end
   if (EVT_W < 2) begin : g_bad_evt
      $error("sq_capture_buf: EVT_W must be at least 2");
   end
   if (SEL_N < 1 || SEL_N > 6) begin : g_bad_sel
      $error("sq_capture_buf: SEL_N must lie in 1..6");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("sq_capture_buf: DATA_W must be positive");
   end

   logic          qual;
   logic          we;
   logic [AW-1:0] waddr;
   logic          capturing;

   sqcb_qualify #(.EVT_W(EVT_W), .SEL_N(SEL_N)) i_qual (
      .evt     (match_evt),
      .evt_sel (qual_sel),
      .tbl     (qual_tbl),
      .en      (qual_en),
      .qual    (qual)
   );

   sqcb_ctrl #(.DEPTH(DEPTH)) i_ctrl (
      .clk       (clk),
      .rst       (rst),
      .arm       (arm),
      .trig      (trig),
      .qual      (qual),
      .post_len  (post_len),
      .we        (we),
      .waddr     (waddr),
      .done      (done),
      .count     (stored_cnt),
      .taddr     (trig_addr),
      .capturing (capturing)
   );

   sqcb_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RD_REG(RD_REG)) i_mem (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (probe_data),
      .raddr (rd_addr),
      .rdata (rd_data)
   );
endmodule

// File: rtl/sqcb_chk.sv
module sqcb_chk #(
   parameter int DEPTH = 64,
   parameter int CW    = 7,
   parameter int AW    = 6
) (
   input logic          clk,
   input logic          rst,
   input logic          arm,
   input logic          qual_en,
   input logic          done,
   input logic          capturing,
   input logic [CW-1:0] stored_cnt,
   input logic [AW-1:0] trig_addr
);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);
   localparam logic [CW-1:0] ONE  = CW'(1);

   // R2
   arm_clears_chk: assert property (@(posedge clk) disable iff (rst)
      arm |=> (!done && stored_cnt == '0 && trig_addr == '0));

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
      stored_cnt <= FULL);

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
      !arm |=> (stored_cnt == $past(stored_cnt) || stored_cnt == $past(stored_cnt) + ONE));

   // R4
   all_stored_chk: assert property (@(posedge clk) disable iff (rst)
      (capturing && !qual_en && !arm && stored_cnt != FULL) |=> stored_cnt == $past(stored_cnt) + ONE);

   // R8
   done_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      (done && !arm) |=> (done && $stable(stored_cnt) && $stable(trig_addr)));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (!capturing && !done && !arm) |=> (stored_cnt == $past(stored_cnt) && !done));
endmodule

bind sq_capture_buf sqcb_chk #(.DEPTH(DEPTH), .CW(CW), .AW(AW)) i_sqcb_chk (
   .clk        (clk),
   .rst        (rst),
   .arm        (arm),
   .qual_en    (qual_en),
   .done       (done),
   .capturing  (capturing),
   .stored_cnt (stored_cnt),
   .trig_addr  (trig_addr)
);

// File: tb/test_sq_capture_buf.sv
module test_sq_capture_buf;
   localparam int DW    = 8;
   localparam int DEPTH = 8;
   localparam int EVT_W = 4;
   localparam int SEL_N = 2;
   localparam int SW    = 2;
   localparam int AW    = 3;
   localparam int CW    = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic arm = 1'b0;
   logic [DW-1:0] probe_data = '0;
   logic [EVT_W-1:0] match_evt = '0;
   logic trig = 1'b0;
   logic qual_en = 1'b0;
   logic [SEL_N*SW-1:0] qual_sel = {2'd3, 2'd1};
   logic [3:0] qual_tbl = '0;
   logic [CW-1:0] post_len = '0;
   logic done;
   logic [CW-1:0] stored_cnt;
   logic [AW-1:0] trig_addr;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;

   always #5 clk = ~clk;

   sq_capture_buf #(.DATA_W(DW), .DEPTH(DEPTH), .EVT_W(EVT_W), .SEL_N(SEL_N)) i_sq_capture_buf (
      .clk(clk), .rst(rst), .arm(arm), .probe_data(probe_data), .match_evt(match_evt),
      .trig(trig), .qual_en(qual_en), .qual_sel(qual_sel), .qual_tbl(qual_tbl),
      .post_len(post_len), .done(done), .stored_cnt(stored_cnt), .trig_addr(trig_addr),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   int total = 0;
   int fails = 0;
   logic [DW-1:0] dseq = 8'h11;

   // reference model built from the requirements
   int m_st = 0;          // 0 idle, 1 pre, 2 post, 3 done
   int m_wp = 0, m_cnt = 0, m_rem = 0, m_ta = 0;
   logic [DW-1:0] m_mem [DEPTH];

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   task automatic model_step();
      int st, wp, pe;
      bit q, store;
      st = m_st; wp = m_wp;
      if (arm) begin
         m_st = 1; m_wp = 0; m_cnt = 0; m_rem = 0; m_ta = 0;
      end else begin
         q = qual_en ? qual_tbl[{match_evt[3], match_evt[1]}] : 1'b1;
         store = (st == 1 && (q || trig)) || (st == 2 && q);
         if (store) begin
            m_mem[wp] = probe_data;
            m_wp = (wp + 1) % DEPTH;
            if (m_cnt < DEPTH) m_cnt++;
         end
         if (st == 1 && trig) begin
            pe = (int'(post_len) > DEPTH - 1) ? DEPTH - 1 : int'(post_len);
            m_ta = wp; m_rem = pe;
            m_st = (pe == 0) ? 3 : 2;
         end else if (st == 2 && q) begin
            m_rem--;
            if (m_rem == 0) m_st = 3;
         end
      end
   endtask

   task automatic cyc(logic [DW-1:0] d, logic [EVT_W-1:0] e, logic t);
      probe_data = d; match_evt = e; trig = t;
      @(posedge clk);
      model_step();
      @(negedge clk);
      trig = 1'b0;
   endtask

   task automatic do_arm();
      arm = 1'b1;
      cyc(dseq, '0, 1'b0);
      arm = 1'b0;
   endtask

   task automatic run(int n, int trig_at);
      for (int i = 0; i < n; i++) begin
         dseq = dseq + 8'd7;
         cyc(dseq, EVT_W'(i), i == trig_at);
      end
   endtask

   task automatic check_all(string tag);
      chk({tag, " done"}, int'(done), (m_st == 3) ? 1 : 0);
      chk({tag, " stored_cnt"}, int'(stored_cnt), m_cnt);
      chk({tag, " trig_addr"}, int'(trig_addr), m_ta);
      for (int a = 0; a < m_cnt; a++) begin
         rd_addr = AW'(a);
         @(posedge clk);
         @(negedge clk);
         chk({tag, " R9 rd_data"}, int'(rd_data), int'(m_mem[a]));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; total++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset values
      chk("R1 done", int'(done), 0);
      chk("R1 stored_cnt", int'(stored_cnt), 0);
      chk("R1 trig_addr", int'(trig_addr), 0);
      // R1: activity before arm is ignored
      qual_en = 1'b0;
      run(6, 2);
      check_all("R1 idle");

      // R3: every truth table, event bits stepping through all combinations
      for (int t = 0; t < 16; t++) begin
         qual_tbl = 4'(t); qual_en = 1'b1; post_len = 4'd3;
         do_arm();
         run(24, 6);
         check_all("R3 table sweep");
      end

      // R4 / R5: qualifier off, early trigger leaves a partial fill
      qual_en = 1'b0; post_len = 4'd1;
      do_arm();
      run(8, 2);
      check_all("R4 R5 partial fill");
      chk("R5 partial count", int'(stored_cnt), 4);

      // R5: wrap-around with late trigger
      post_len = 4'd3;
      do_arm();
      run(30, 20);
      check_all("R5 wrap");
      chk("R5 wrap trig_addr", int'(trig_addr), 4);
      chk("R5 saturated count", int'(stored_cnt), DEPTH);

      // R7: post_len beyond the depth is clamped
      post_len = 4'd15;
      do_arm();
      run(20, 3);
      check_all("R7 clamp");

      // R8: triggers and data after done change nothing
      run(10, 4);
      check_all("R8 frozen");

      // R7: post_len of zero
      post_len = 4'd0;
      do_arm();
      run(2, 1);
      chk("R7 zero post done", int'(done), 1);
      check_all("R7 zero post");

      // R6: trigger sample forced in although no sample qualifies
      qual_en = 1'b1; qual_tbl = 4'd0;
      do_arm();
      run(6, 3);
      chk("R6 forced count", int'(stored_cnt), 1);
      check_all("R6 forced");

      // R2: arm clears done and count
      do_arm();
      chk("R2 done cleared", int'(done), 0);
      chk("R2 count cleared", int'(stored_cnt), 0);
      chk("R2 trig_addr cleared", int'(trig_addr), 0);

      report();
   end
endmodule